// File: doc/BRIEF.md
# Multi-Lane Receive Error Detector

This block sits beside the receive path of a multi-lane serial link and turns low-level lane events into one correctable receive-port error class. Each lane supplies a 3-bit receive status code with a valid strobe and a flag raised when a control symbol turns up on a lane where it is not allowed. Two link-wide inputs complete the picture: a flag saying the link is in its active L0 state, and an overflow flag from the multi-lane deskew FIFO.

Coding-sublayer status errors count only while the link is in L0. Deskew overflow and misplaced control symbols count in any state. Every event lands in a six-bit sticky cause register with write-one-to-clear. Coding errors also mark their lane in a sticky lane mask. A registered pulse follows any cycle that held at least one event. All of these errors are correctable. The consumer raises its correctable-error message from the pulse and reads the causes at leisure.

Top module: `rx_err_detect`

## Requirements
- R1: A valid status code in L0 sets one cause bit: 3'b100 (decode) sets bit 0, 3'b101 (elastic overflow) sets bit 1, 3'b110 (elastic underflow) sets bit 2, 3'b111 (disparity) sets bit 3 of `cause_o`.
- R2: Status codes 3'b000 to 3'b011 set no cause bit, no lane bit and no pulse.
- R3: A status code has no effect when its lane's valid strobe is low or when `link_l0_i` is low.
- R4: A high `deskew_ovf_i` sets cause bit 4 in any link state.
- R5: A high `bad_sym_i` bit on any lane sets cause bit 5 in any link state, and does not change `lane_mask_o`.
- R6: `err_pulse_o` is high in exactly the cycle after each cycle holding at least one event from R1, R4 or R5, and low otherwise.
- R7: A cause or lane bit stays set until a one is written to its bit of `cause_clr_i` or `lane_clr_i`, which clears it at the next edge.
- R8: An event in the same cycle as a clear of the same bit leaves the bit set.
- R9: Bit n of `lane_mask_o` is set one cycle after lane n reports an R1 coding error.
- R10: After reset, `err_pulse_o`, `cause_o` and `lane_mask_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_status_i | input | 3*NUM_LANES | Receive status code, lane n at bits [3n+2:3n] |
| lane_valid_i | input | NUM_LANES | Status code valid, per lane |
| bad_sym_i | input | NUM_LANES | Control symbol on a disallowed lane |
| link_l0_i | input | 1 | Link is in the L0 state |
| deskew_ovf_i | input | 1 | Deskew FIFO overflow |
| cause_clr_i | input | 6 | Write-one-to-clear for cause bits |
| lane_clr_i | input | NUM_LANES | Write-one-to-clear for lane mask bits |
| err_pulse_o | output | 1 | Correctable receive error pulse |
| cause_o | output | 6 | Sticky cause bits |
| lane_mask_o | output | NUM_LANES | Sticky lanes with coding errors |

## Verification
Single-lane codes tell the four error codes apart, and a cycle with three lanes carrying different codes shows that causes merge and lane bits stay separate. Benign codes, invalid strobes and coding errors outside L0 are each expected to leave every output untouched. Deskew overflow and misplaced symbols are driven outside L0 to show they bypass the state gate. Clears issued alone and together with a fresh event separate plain clearing from event-wins priority.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;
  localparam int unsigned NUM_CAUSES = 6;

  typedef enum logic [2:0] {
    CAUSE_DECODE    = 3'd0,
    CAUSE_EB_OVF    = 3'd1,
    CAUSE_EB_UNF    = 3'd2,
    CAUSE_DISPARITY = 3'd3,
    CAUSE_DESKEW    = 3'd4,
    CAUSE_BAD_SYM   = 3'd5
  } cause_e;

  // Codes with the top bit set are errors; low two bits select the cause.
  function automatic logic [3:0] code_to_cause(input logic [2:0] code);
    logic [3:0] v;
    v = '0;
    if (code[2]) v[code[1:0]] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/rx_lane_decode.sv
module rx_lane_decode
  import rx_err_pkg::*;
(
  input  logic [2:0] status_i,
  input  logic       valid_i,
  input  logic       link_l0_i,
  output logic [3:0] coding_o,
  output logic       hit_o
);
  always_comb begin
    coding_o = '0;
    if (valid_i && link_l0_i) coding_o = code_to_cause(status_i);
  end

  assign hit_o = |coding_o;

  always_comb begin
    if (!(valid_i && link_l0_i)) p_gate_r3: assert (coding_o == '0);
    if (valid_i && !status_i[2]) p_benign_r2: assert (coding_o == '0);
  end
endmodule

// File: rtl/rx_w1c_reg.sv
module rx_w1c_reg #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_d;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign q_d[b] = set_i[b] | (q_o[b] & ~clr_i[b]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(set_i & clr_i) |=> ((q_o & $past(set_i & clr_i)) == $past(set_i & clr_i)));
  p_no_spurious_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((q_o & ~$past(q_o) & ~$past(set_i)) == '0));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(q_o) & ~$past(clr_i) & ~q_o) == '0));
endmodule

// File: rtl/rx_err_detect.sv
module rx_err_detect
  import rx_err_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [3*NUM_LANES-1:0] lane_status_i,
  input  logic [NUM_LANES-1:0]   lane_valid_i,
  input  logic [NUM_LANES-1:0]   bad_sym_i,
  input  logic                   link_l0_i,
  input  logic                   deskew_ovf_i,
  input  logic [NUM_CAUSES-1:0]  cause_clr_i,
  input  logic [NUM_LANES-1:0]   lane_clr_i,
  output logic                   err_pulse_o,
  output logic [NUM_CAUSES-1:0]  cause_o,
  output logic [NUM_LANES-1:0]   lane_mask_o
);
  localparam int unsigned CODE_W = 3;

  logic [3:0]            lane_coding [NUM_LANES];
  logic [NUM_LANES-1:0]  lane_hit;
  logic [3:0]            coding_any;
  logic [NUM_CAUSES-1:0] cause_set;
  logic                  any_event;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    rx_lane_decode u_dec (
      .status_i (lane_status_i[CODE_W*l +: CODE_W]),
      .valid_i  (lane_valid_i[l]),
      .link_l0_i(link_l0_i),
      .coding_o (lane_coding[l]),
      .hit_o    (lane_hit[l])
    );
  end

  always_comb begin
    coding_any = '0;
    for (int l = 0; l < NUM_LANES; l++) coding_any |= lane_coding[l];
  end

  always_comb begin
    cause_set = '0;
    cause_set[3:0]           = coding_any;
    cause_set[CAUSE_DESKEW]  = deskew_ovf_i;
    cause_set[CAUSE_BAD_SYM] = |bad_sym_i;
  end

  assign any_event = |cause_set;

  rx_w1c_reg #(.WIDTH(NUM_CAUSES)) u_cause (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (cause_set),
    .clr_i (cause_clr_i),
    .q_o   (cause_o)
  );

  rx_w1c_reg #(.WIDTH(NUM_LANES)) u_lanes (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (lane_hit),
    .clr_i (lane_clr_i),
    .q_o   (lane_mask_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_pulse_o <= 1'b0;
    else         err_pulse_o <= any_event;
  end

  p_pulse_after_event_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deskew_ovf_i || (|bad_sym_i)) |=> err_pulse_o);
  p_pulse_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_set == '0) |=> !err_pulse_o);
  p_lane_implies_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lane_hit) |=> (cause_o[3:0] != '0) && (lane_mask_o != '0));
  p_badsym_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bad_sym_i) |=> cause_o[CAUSE_BAD_SYM]);
  p_deskew_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deskew_ovf_i |=> cause_o[CAUSE_DESKEW]);
endmodule

// File: tb/rx_err_detect_tb.sv
`timescale 1ns/1ps
module rx_err_detect_tb;
  localparam int NL = 4;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [3*NL-1:0] st = '0;
  logic [NL-1:0]   vld = '0, bsym = '0, lclr = '0;
  logic            l0 = 1'b0, dsk = 1'b0;
  logic [5:0]      cclr = '0;
  logic            pulse;
  logic [5:0]      cause;
  logic [NL-1:0]   mask;

  int checks = 0, failures = 0;

  typedef struct {
    logic          pulse;
    logic [5:0]    cause;
    logic [NL-1:0] mask;
    string         tag;
  } exp_t;
  exp_t sb[$];

  logic [5:0]    m_cause = '0;
  logic [NL-1:0] m_mask  = '0;

  always #5 clk = ~clk;

  rx_err_detect #(.NUM_LANES(NL)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .lane_status_i(st), .lane_valid_i(vld),
    .bad_sym_i(bsym), .link_l0_i(l0), .deskew_ovf_i(dsk),
    .cause_clr_i(cclr), .lane_clr_i(lclr),
    .err_pulse_o(pulse), .cause_o(cause), .lane_mask_o(mask)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic step(input logic [3*NL-1:0] s, input logic [NL-1:0] v,
                      input logic [NL-1:0] b, input logic l, input logic d,
                      input logic [5:0] cc, input logic [NL-1:0] lc, input string tag);
    exp_t e;
    logic [5:0] ev;
    logic [NL-1:0] lh;
    @(negedge clk);
    st = s; vld = v; bsym = b; l0 = l; dsk = d; cclr = cc; lclr = lc;
    ev = '0; lh = '0;
    for (int i = 0; i < NL; i++) begin
      logic [2:0] c;
      c = s[3*i +: 3];
      if (v[i] && l && c[2]) begin
        ev[c[1:0]] = 1'b1;
        lh[i] = 1'b1;
      end
    end
    ev[4] = d;
    ev[5] = |b;
    m_cause = (m_cause & ~cc) | ev;
    m_mask  = (m_mask & ~lc) | lh;
    e.pulse = |ev; e.cause = m_cause; e.mask = m_mask; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    step('0, '0, '0, 1'b1, 1'b0, '0, '0, tag);
  endtask

  // Monitor: compares just after the edge that consumed the queued stimulus.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "pulse", int'(pulse), int'(e.pulse));
        chk(e.tag, "cause", int'(cause), int'(e.cause));
        chk(e.tag, "mask",  int'(mask),  int'(e.mask));
      end
    end
  end

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "pulse", int'(pulse), 0);
    chk("R10", "cause", int'(cause), 0);
    chk("R10", "mask",  int'(mask), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10", "cause after release", int'(cause), 0);

    step({3'b000, 3'b000, 3'b000, 3'b100}, 4'b0001, '0, 1'b1, 1'b0, '0, '0, "R1_decode_R9");
    idle("R6_quiet_R7_hold");
    step({3'b111, 3'b110, 3'b101, 3'b000}, 4'b1110, '0, 1'b1, 1'b0, '0, '0, "R1_multi_R9");
    idle("R7_hold");
    step('0, '0, '0, 1'b1, 1'b0, 6'h3f, 4'hf, "R7_clear");
    step({3'b011, 3'b010, 3'b001, 3'b000}, 4'hf, '0, 1'b1, 1'b0, '0, '0, "R2_benign");
    step({3'b100, 3'b101, 3'b110, 3'b111}, 4'hf, '0, 1'b0, 1'b0, '0, '0, "R3_not_l0");
    step({3'b100, 3'b101, 3'b110, 3'b111}, 4'h0, '0, 1'b1, 1'b0, '0, '0, "R3_invalid");
    step('0, '0, '0, 1'b0, 1'b1, '0, '0, "R4_deskew");
    step('0, '0, 4'b0100, 1'b0, 1'b0, '0, '0, "R5_bad_sym");
    idle("R6_quiet");
    step('0, '0, '0, 1'b1, 1'b1, 6'h30, '0, "R8_deskew_vs_clr");
    step({3'b000, 3'b000, 3'b111, 3'b000}, 4'b0010, '0, 1'b1, 1'b0, 6'h08, 4'b0010, "R8_lane_vs_clr");
    step('0, '0, '0, 1'b1, 1'b0, 6'h10, 4'b0010, "R7_partial_clear");
    step({3'b110, 3'b000, 3'b000, 3'b000}, 4'b1000, 4'b0001, 1'b1, 1'b1, '0, '0, "R6_all_R9");
    idle("R6_quiet");
    idle("R7_hold_end");
    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule